// File: doc/BRIEF.md
# Serial Add-Three State Machine

This block adds the constant three to a stream of 4-bit numbers that arrive one bit per clock on a single line, least significant bit first. For each incoming bit it returns the matching bit of the sum on the same cycle, so the sum leaves the block LSB first with no latency. On the last bit of each group of four it also reports whether the true sum exceeded fifteen. The block is a seven-state Mealy machine whose register moves on the falling clock edge, and it realigns to a new word by itself after every fourth bit.

The states track which bit position is next and whether a carry is pending. They are named, with their fixed binary codes: ST_IDLE (000, bit 0 next), ST_B1_NC (010, bit 1, no carry), ST_B1_CY (001, bit 1, carry), ST_B2_NC (101, bit 2, no carry), ST_B2_CY (011, bit 2, carry), ST_B3_NC (100, bit 3, no carry), ST_B3_CY (111, bit 3, carry). The transitions are listed as input 0 then input 1, each with its sum/overflow output: ST_IDLE to ST_B1_NC (1/0) or ST_B1_CY (0/0); ST_B1_NC to ST_B2_NC (1/0) or ST_B2_CY (0/0); ST_B1_CY to ST_B2_CY (0/0) or ST_B2_CY (1/0); ST_B2_NC to ST_B3_NC (0/0) or ST_B3_NC (1/0); ST_B2_CY to ST_B3_NC (1/0) or ST_B3_CY (0/0); ST_B3_NC to ST_IDLE (0/0) or ST_IDLE (1/0); ST_B3_CY to ST_IDLE (1/0) or ST_IDLE (0/1). The single unused code 110 returns to ST_IDLE with both outputs low.

Top module: `serial_add3_fsm`

## Requirements
- R1: An active-high asynchronous reset places the machine in its start state: while reset is high, sum_o equals the inverse of x_in and ovf_o is 0, and the first bit after reset is treated as bit 0 of a new word, even when reset arrives part-way through a word.
- R2: The state register changes only on falling clock edges; between edges sum_o and ovf_o are combinational functions of the present state and x_in, so changing x_in within a cycle changes sum_o at once.
- R3: Over the four cycles of a word, sum_o carries bits 0 to 3 of (N + 3) mod 16 in that order, including words where the sum overflows.
- R4: ovf_o is 1 only on bit 3 of a word and only when N + 3 is greater than 15 (N of 13, 14 or 15); on bits 0 to 2 it is always 0.
- R5: After bit 3 the machine returns to its start state with no external action, so words sent back to back with no gap are each summed correctly.
- R6: Every one of the fourteen state and input pairs follows the transition list above; sending all sixteen values of N drives every pair.
- R7: The word sequence 13, 12, 11 yields sum bits 0,0,0,0 with overflow on bit 3, then 1,1,1,1, then 0,1,1,1, both without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state moves on its falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| x_in | input | 1 | Serial operand bit, LSB first |
| sum_o | output | 1 | Serial sum bit for the current input bit |
| ovf_o | output | 1 | Overflow flag, valid on bit 3 of a word |

## Verification
Both outputs are due in the same cycle as the input bit that produces them, since they are combinational in the present state and x_in; the bit is then consumed at the next falling edge. The bench drives x_in 1.25 ns after each rising edge and compares 1.0 ns later, a quarter nanosecond before the falling edge, so every comparison sees the state left by the previous falling edge and the new input. The within-cycle probe of R2 toggles x_in between two comparisons in the same high phase, and the reset probe of R1 compares during reset with no clock edge in between.

// File: rtl/serial_add3_pkg.sv
`timescale 1ns/1ps
package serial_add3_pkg;

    localparam int WORD_BITS = 4;
    localparam int ADDEND    = 3;
    localparam int STATE_W   = 3;
    localparam int POS_W     = $clog2(WORD_BITS);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_B1_NC = 3'b010,
        ST_B1_CY = 3'b001,
        ST_B2_NC = 3'b101,
        ST_B2_CY = 3'b011,
        ST_B3_NC = 3'b100,
        ST_B3_CY = 3'b111
    } add3_state_t;

    typedef struct packed {
        logic sum;
        logic ovf;
    } add3_out_t;

endpackage

// File: rtl/add3_state_reg.sv
`timescale 1ns/1ps
module add3_state_reg
    import serial_add3_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  add3_state_t nxt_state,
    output add3_state_t cur_state
);

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end

endmodule

// File: rtl/add3_next_state.sv
`timescale 1ns/1ps
module add3_next_state
    import serial_add3_pkg::*;
(
    input  add3_state_t cur_state,
    input  logic        x_in,
    output add3_state_t nxt_state
);

    always_comb begin
        unique case (cur_state)
            ST_IDLE:  nxt_state = x_in ? ST_B1_CY : ST_B1_NC;
            ST_B1_NC: nxt_state = x_in ? ST_B2_CY : ST_B2_NC;
            ST_B1_CY: nxt_state = ST_B2_CY;
            ST_B2_NC: nxt_state = ST_B3_NC;
            ST_B2_CY: nxt_state = x_in ? ST_B3_CY : ST_B3_NC;
            ST_B3_NC: nxt_state = ST_IDLE;
            ST_B3_CY: nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/add3_out_logic.sv
`timescale 1ns/1ps
module add3_out_logic
    import serial_add3_pkg::*;
(
    input  add3_state_t cur_state,
    input  logic        x_in,
    output add3_out_t   out_bits
);

    always_comb begin
        out_bits = '0;
        unique case (cur_state)
            ST_IDLE:  out_bits.sum = ~x_in;
            ST_B1_NC: out_bits.sum = ~x_in;
            ST_B1_CY: out_bits.sum =  x_in;
            ST_B2_NC: out_bits.sum =  x_in;
            ST_B2_CY: out_bits.sum = ~x_in;
            ST_B3_NC: out_bits.sum =  x_in;
            ST_B3_CY: begin
                out_bits.sum = ~x_in;
                out_bits.ovf =  x_in;
            end
            default:  out_bits = '0;
        endcase
    end

endmodule

// File: rtl/serial_add3_fsm.sv
`timescale 1ns/1ps
module serial_add3_fsm
    import serial_add3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic sum_o,
    output logic ovf_o
);

    add3_state_t state_q;
    add3_state_t state_d;
    add3_out_t   outs;

    add3_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    add3_next_state u_nxt (
        .cur_state (state_q),
        .x_in      (x_in),
        .nxt_state (state_d)
    );

    add3_out_logic u_out (
        .cur_state (state_q),
        .x_in      (x_in),
        .out_bits  (outs)
    );

    assign sum_o = outs.sum;
    assign ovf_o = outs.ovf;

endmodule

// File: rtl/add3_checker.sv
`timescale 1ns/1ps
module add3_checker
    import serial_add3_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               x_in,
    input logic               sum_o,
    input logic               ovf_o,
    input logic [STATE_W-1:0] state_q
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BITS - 1);

    logic [POS_W-1:0]     pos_q;
    logic [WORD_BITS-1:0] acc_q;
    logic [WORD_BITS:0]   partial;
    logic [WORD_BITS:0]   total;
    logic                 exp_sum;
    logic                 exp_ovf;

    always_comb begin
        partial = {1'b0, acc_q} | ({{WORD_BITS{1'b0}}, x_in} << pos_q);
        total   = partial + (WORD_BITS+1)'(ADDEND);
        exp_sum = total[pos_q];
        exp_ovf = (pos_q == LAST_POS) && total[WORD_BITS];
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            pos_q <= '0;
            acc_q <= '0;
        end else begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            acc_q <= (pos_q == LAST_POS) ? '0 : partial[WORD_BITS-1:0];
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            a_r1_reset_idle: assert (state_q == 3'b000)
                else $error("R1: state not idle under reset");
        end
    end

    a_r3_sum_bit: assert property (@(negedge clk) disable iff (rst)
        sum_o == exp_sum);

    a_r4_ovf_value: assert property (@(negedge clk) disable iff (rst)
        ovf_o == exp_ovf);

    a_r4_ovf_last_only: assert property (@(negedge clk) disable iff (rst)
        ovf_o |-> (pos_q == LAST_POS));

    a_r5_restart: assert property (@(negedge clk) disable iff (rst)
        (pos_q == LAST_POS) |=> (state_q == 3'b000));

    a_r6_state_legal: assert property (@(negedge clk) disable iff (rst)
        state_q != 3'b110);

endmodule

bind serial_add3_fsm add3_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .sum_o   (sum_o),
    .ovf_o   (ovf_o),
    .state_q (state_q)
);

// File: tb/serial_add3_fsm_tb_top.sv
`timescale 1ns/1ps
module serial_add3_fsm_tb_top;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic x_in = 1'b0;
    logic sum_o;
    logic ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    serial_add3_fsm dut_i (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .sum_o (sum_o),
        .ovf_o (ovf_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic ref_sum(input int n, input int k);
        return 1'(((n + 3) >> k) & 1);
    endfunction

    function automatic logic ref_ovf(input int n, input int k);
        return (k == 3) && (n + 3 > 15);
    endfunction

    task automatic send_word(input int n, input string req);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1.25 x_in = 1'(n >> k);
            #1.0;
            check(req, $sformatf("N=%0d bit%0d sum", n, k), sum_o, ref_sum(n, k));
            check(req, $sformatf("N=%0d bit%0d ovf", n, k), ovf_o, ref_ovf(n, k));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int words[$];

        // R1: reset state seen at the ports
        @(negedge clk);
        #0.5 x_in = 1'b0;
        #0.2 check("R1", "reset sum x=0", sum_o, 1'b1);
        check("R1", "reset ovf x=0", ovf_o, 1'b0);
        x_in = 1'b1;
        #0.2 check("R1", "reset sum x=1", sum_o, 1'b0);
        check("R1", "reset ovf x=1", ovf_o, 1'b0);
        @(negedge clk);
        #0.5 rst = 1'b0;

        // R7: the given sequence, back to back (R5)
        words = {13, 12, 11};
        foreach (words[i]) send_word(words[i], "R7");

        // R6, R3, R4, R5: every value, no gaps
        for (int n = 0; n < 16; n++) words.push_back(n);
        foreach (words[i]) if (i >= 3) send_word(words[i], "R6");

        // R2: Mealy output follows x_in within a cycle (bit 0 in idle)
        @(posedge clk);
        #1.25 x_in = 1'b0;
        #0.5 check("R2", "probe sum x=0", sum_o, 1'b1);
        x_in = 1'b1;
        #0.5 check("R2", "probe sum x=1", sum_o, 1'b0);
        // bit 0 of N=15 consumed; finish that word
        for (int k = 1; k < 4; k++) begin
            @(posedge clk);
            #1.25 x_in = 1'b1;
            #1.0;
            check("R2", $sformatf("N=15 bit%0d sum", k), sum_o, ref_sum(15, k));
            check("R4", $sformatf("N=15 bit%0d ovf", k), ovf_o, ref_ovf(15, k));
        end

        // R1: asynchronous reset in mid-word, then realignment
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            #1.25 x_in = 1'(6 >> k);
            #1.0 check("R3", $sformatf("N=6 bit%0d sum", k), sum_o, ref_sum(6, k));
        end
        @(posedge clk);
        #1.25 x_in = 1'b0;
        rst = 1'b1;
        #0.2 check("R1", "mid-word reset sum x=0", sum_o, 1'b1);
        check("R1", "mid-word reset ovf", ovf_o, 1'b0);
        x_in = 1'b1;
        #0.2 check("R1", "mid-word reset sum x=1", sum_o, 1'b0);
        @(negedge clk);
        #0.5 rst = 1'b0;
        send_word(13, "R1");
        send_word(14, "R4");
        send_word(2, "R5");

        done = 1'b1;
        finish_run();
    end

endmodule